// File: doc/BRIEF.md
# Sideband AUX request formatter

This block takes one sideband AUX request (a 4-bit command, a 16-bit address, a payload size and up to sixteen payload bytes) and turns it into a byte stream on a valid/ready interface, one byte per accepted cycle. The frame always starts with a four-byte header. Write requests add their payload after the header. Read requests send only the header. A request that cannot be formed is refused straight away: either the size exceeds the payload limit or the command is not one of the four read/write kinds. A refused request sends no bytes.

When the last byte has gone out, the block waits for one reply beat. The beat carries a status code, the sink's reply byte and the number of data bytes that follow. A successful read then takes in that many data bytes. It forwards only as many as were requested and drops the rest. Every request ends with a single-cycle completion pulse. The pulse carries a result code, the reply nibble and the number of bytes received.

The controller is an enumerated state machine with five states.
- IDLE accepts a request. It goes to SEND, or to DONE when the request is refused.
- SEND shifts the frame out. It goes to WAIT_RSP when the last byte is taken.
- WAIT_RSP takes the reply beat. It goes to TAKE_DATA for a successful read that has data, and to DONE otherwise.
- TAKE_DATA takes in the returned bytes. It goes to DONE after the final byte.
- DONE raises the completion pulse for one cycle and returns to IDLE.

Top module: `aux_req_fmt`

## Requirements
- R1: A request with a size above 16 is refused in its accept cycle. The completion pulse follows on the next cycle with code 4, and no byte is emitted.
- R2: Command encodings are: 0 = I2C write, 1 = I2C read, 8 = native write, 9 = native read. Bit 2 (middle-of-transaction) is ignored when classifying the command. Any other command is refused with code 4'h5 (completion code 5) on the next cycle, and no byte is emitted. An over-size request reports code 4 even if its command is also invalid.
- R3: Frame byte 0 is address bits 7:0. Byte 1 is address bits 15:8. Byte 2 is the command in bits 7:4 with zeros in bits 3:0.
- R4: Bits 3:0 of frame byte 3 hold the size minus one, or 0 when the size is zero.
- R5: A write with a non-zero size emits 4 + size bytes, with the payload bytes in index order after the header. Bits 7:4 of byte 3 hold (4 + size) modulo 16.
- R6: A zero-size request of either direction emits exactly 4 bytes, and bits 7:4 of byte 3 are 3.
- R7: A read emits exactly 4 bytes. When its size is non-zero, bits 7:4 of byte 3 are 4.
- R8: Reply status 1 completes with code 1 (timeout), status 2 with code 2 (flags set), and status 3 with code 3 (error). These complete with reply nibble 0 and byte count 0, and take no data bytes.
- R9: Any other status is success (code 0), and the reply nibble is bits 7:4 of the reply byte. A read takes exactly the returned length of data bytes and forwards the first min(returned, size) of them on the read-data port; its byte count is that minimum. A write reports its own size as the count.
- R10: The request input is not ready from acceptance until the completion pulse. tx_last marks the final frame byte, and a byte held under backpressure keeps its value.
- R11: The completion pulse lasts exactly one cycle, after which the block is ready again. After reset it is ready and all valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_cmd | input | 4 | Command nibble |
| req_addr | input | 16 | Target address |
| req_size | input | 5 | Payload size in bytes |
| req_payload | input | 128 | Write payload, byte k in bits 8k+7:8k |
| tx_valid | output | 1 | Frame byte present |
| tx_ready | input | 1 | Downstream takes the frame byte |
| tx_byte | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| rsp_valid | input | 1 | Reply beat present |
| rsp_ready | output | 1 | Block waiting for the reply beat |
| rsp_status | input | 8 | Reply status code |
| rsp_reply | input | 8 | Sink reply byte |
| rsp_len | input | 8 | Number of data bytes that follow |
| rx_valid | input | 1 | Returned data byte present |
| rx_ready | output | 1 | Block taking returned data |
| rx_byte | input | 8 | Returned data byte |
| rd_valid | output | 1 | Forwarded read byte |
| rd_byte | output | 8 | Forwarded read byte value |
| done_valid | output | 1 | Completion pulse |
| done_code | output | 3 | 0 ok, 1 timeout, 2 flags, 3 error, 4 too big, 5 bad command |
| done_reply | output | 4 | Sink reply nibble |
| done_count | output | 5 | Bytes received (reads) or size (writes) |

## Verification
The hardest case to reach from the ports is a read where the sink returns more bytes than were requested, so forwarding stops part-way through the data phase. It must also be shown that this happens only after a frame was held under downstream backpressure. The sweep covers every command nibble at every size from 0 to 17. It stalls tx_ready on every third cycle, and it derives the status and returned length from the command and size. This way every reply status meets both shorter and longer returned lengths at many sizes, and the bench compares each byte and each completion with arithmetic expectations.

// File: rtl/aux_fmt_pkg.sv
package aux_fmt_pkg;

    localparam int HDR_BYTES = 4;

    localparam logic [3:0] CMD_I2C_WR  = 4'h0;
    localparam logic [3:0] CMD_I2C_RD  = 4'h1;
    localparam logic [3:0] CMD_NAT_WR  = 4'h8;
    localparam logic [3:0] CMD_NAT_RD  = 4'h9;
    localparam logic [3:0] CMD_MOT_BIT = 4'h4;

    localparam logic [3:0] BARE_LEN_NIB = 4'd3;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SEND      = 3'd1,
        ST_WAIT_RSP  = 3'd2,
        ST_TAKE_DATA = 3'd3,
        ST_DONE      = 3'd4
    } fmt_state_t;

    typedef enum logic [2:0] {
        CPL_OK      = 3'd0,
        CPL_TIMEOUT = 3'd1,
        CPL_FLAGS   = 3'd2,
        CPL_ERROR   = 3'd3,
        CPL_TOO_BIG = 3'd4,
        CPL_BAD_CMD = 3'd5
    } cpl_code_t;

endpackage

// File: rtl/aux_hdr_build.sv
module aux_hdr_build
    import aux_fmt_pkg::*;
#(
    parameter int MAX_PAYLOAD = 16,
    parameter int SIZE_W      = 5,
    parameter int IDX_W       = 5
) (
    input  logic [3:0]                      cmd,
    input  logic [15:0]                     addr,
    input  logic [SIZE_W-1:0]               size,
    output logic [HDR_BYTES-1:0][7:0]       hdr,
    output logic [IDX_W-1:0]                frame_len,
    output logic                            is_read,
    output logic                            cmd_ok,
    output logic                            size_ok
);

    logic [3:0]       base_cmd;
    logic [IDX_W-1:0] total_len;
    logic [3:0]       lo_nib;
    logic [3:0]       hi_nib;

    always_comb begin
        base_cmd  = cmd & ~CMD_MOT_BIT;
        cmd_ok    = (base_cmd == CMD_I2C_WR) || (base_cmd == CMD_I2C_RD) ||
                    (base_cmd == CMD_NAT_WR) || (base_cmd == CMD_NAT_RD);
        is_read   = base_cmd[0];
        size_ok   = (size <= SIZE_W'(MAX_PAYLOAD));
        total_len = IDX_W'(HDR_BYTES) + IDX_W'(size);

        if (size == '0) begin
            lo_nib = 4'd0;
        end else begin
            lo_nib = 4'(size - SIZE_W'(1));
        end

        if (size == '0) begin
            hi_nib = BARE_LEN_NIB;
        end else if (is_read) begin
            hi_nib = 4'(HDR_BYTES);
        end else begin
            hi_nib = total_len[3:0];
        end

        hdr[0]    = addr[7:0];
        hdr[1]    = addr[15:8];
        hdr[2]    = {cmd, 4'h0};
        hdr[3]    = {hi_nib, lo_nib};
        frame_len = is_read ? IDX_W'(HDR_BYTES) : total_len;
    end

endmodule

// File: rtl/aux_tx_shift.sv
module aux_tx_shift
    import aux_fmt_pkg::*;
#(
    parameter int MAX_PAYLOAD = 16,
    parameter int IDX_W       = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic                          advance,
    input  logic [HDR_BYTES-1:0][7:0]     hdr,
    input  logic [MAX_PAYLOAD*8-1:0]      payload,
    input  logic [IDX_W-1:0]              len_in,
    output logic [7:0]                    cur_byte,
    output logic                          cur_last
);

    localparam int FRAME_MAX = HDR_BYTES + MAX_PAYLOAD;
    localparam int FRAME_W   = FRAME_MAX * 8;

    logic [FRAME_W-1:0] load_vec;
    logic [FRAME_W-1:0] frame_q;
    logic [IDX_W-1:0]   idx_q;
    logic [IDX_W-1:0]   len_q;

    for (genvar g = 0; g < FRAME_MAX; g++) begin : g_slot
        if (g < HDR_BYTES) begin : g_hdr
            assign load_vec[g*8 +: 8] = hdr[g];
        end else begin : g_pay
            assign load_vec[g*8 +: 8] = payload[(g-HDR_BYTES)*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            idx_q   <= '0;
            len_q   <= '0;
        end else if (load) begin
            frame_q <= load_vec;
            idx_q   <= '0;
            len_q   <= len_in;
        end else if (advance) begin
            idx_q   <= idx_q + IDX_W'(1);
        end
    end

    always_comb begin
        cur_byte = '0;
        for (int b = 0; b < FRAME_MAX; b++) begin
            if (idx_q == IDX_W'(b)) begin
                cur_byte = frame_q[b*8 +: 8];
            end
        end
        cur_last = (idx_q == (len_q - IDX_W'(1)));
    end

endmodule

// File: rtl/aux_rsp_decode.sv
module aux_rsp_decode
    import aux_fmt_pkg::*;
#(
    parameter int SIZE_W = 5,
    parameter int RLEN_W = 8
) (
    input  logic [7:0]        status,
    input  logic [7:0]        reply,
    input  logic [RLEN_W-1:0] rlen,
    input  logic [SIZE_W-1:0] size,
    input  logic              is_read,
    output cpl_code_t         code,
    output logic [3:0]        nibble,
    output logic [SIZE_W-1:0] keep_cnt,
    output logic              take_data
);

    logic ok;

    always_comb begin
        ok = !((status == 8'd1) || (status == 8'd2) || (status == 8'd3));
        code   = ok ? CPL_OK : cpl_code_t'(status[2:0]);
        nibble = ok ? 4'(reply >> 4) : 4'd0;

        if (!ok) begin
            keep_cnt = '0;
        end else if (!is_read) begin
            keep_cnt = size;
        end else if (rlen < RLEN_W'(size)) begin
            keep_cnt = SIZE_W'(rlen);
        end else begin
            keep_cnt = size;
        end

        take_data = ok && is_read && (rlen != '0);
    end

endmodule

// File: rtl/aux_req_fmt.sv
module aux_req_fmt
    import aux_fmt_pkg::*;
#(
    parameter int MAX_PAYLOAD = 16,
    parameter int SIZE_W      = 5,
    parameter int RLEN_W      = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [3:0]                 req_cmd,
    input  logic [15:0]                req_addr,
    input  logic [SIZE_W-1:0]          req_size,
    input  logic [MAX_PAYLOAD*8-1:0]   req_payload,
    output logic                       tx_valid,
    input  logic                       tx_ready,
    output logic [7:0]                 tx_byte,
    output logic                       tx_last,
    input  logic                       rsp_valid,
    output logic                       rsp_ready,
    input  logic [7:0]                 rsp_status,
    input  logic [7:0]                 rsp_reply,
    input  logic [RLEN_W-1:0]          rsp_len,
    input  logic                       rx_valid,
    output logic                       rx_ready,
    input  logic [7:0]                 rx_byte,
    output logic                       rd_valid,
    output logic [7:0]                 rd_byte,
    output logic                       done_valid,
    output logic [2:0]                 done_code,
    output logic [3:0]                 done_reply,
    output logic [SIZE_W-1:0]          done_count
);

    localparam int IDX_W = $clog2(HDR_BYTES + MAX_PAYLOAD + 1);

    fmt_state_t state_q, state_d;

    logic [HDR_BYTES-1:0][7:0] hdr;
    logic [IDX_W-1:0]          frame_len;
    logic                      is_read, cmd_ok, size_ok;
    logic [7:0]                cur_byte;
    logic                      cur_last;
    logic                      load, advance;

    cpl_code_t                 dec_code;
    logic [3:0]                dec_nib;
    logic [SIZE_W-1:0]         dec_keep;
    logic                      dec_take;

    logic [SIZE_W-1:0]         size_q;
    logic                      is_read_q;
    cpl_code_t                 code_q;
    logic [3:0]                reply_q;
    logic [SIZE_W-1:0]         count_q;
    logic [RLEN_W-1:0]         rem_q;
    logic [SIZE_W-1:0]         taken_q;
    logic                      fwd;

    aux_hdr_build #(
        .MAX_PAYLOAD (MAX_PAYLOAD),
        .SIZE_W      (SIZE_W),
        .IDX_W       (IDX_W)
    ) u_hdr (
        .cmd       (req_cmd),
        .addr      (req_addr),
        .size      (req_size),
        .hdr       (hdr),
        .frame_len (frame_len),
        .is_read   (is_read),
        .cmd_ok    (cmd_ok),
        .size_ok   (size_ok)
    );

    aux_tx_shift #(
        .MAX_PAYLOAD (MAX_PAYLOAD),
        .IDX_W       (IDX_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .advance  (advance),
        .hdr      (hdr),
        .payload  (req_payload),
        .len_in   (frame_len),
        .cur_byte (cur_byte),
        .cur_last (cur_last)
    );

    aux_rsp_decode #(
        .SIZE_W (SIZE_W),
        .RLEN_W (RLEN_W)
    ) u_dec (
        .status    (rsp_status),
        .reply     (rsp_reply),
        .rlen      (rsp_len),
        .size      (size_q),
        .is_read   (is_read_q),
        .code      (dec_code),
        .nibble    (dec_nib),
        .keep_cnt  (dec_keep),
        .take_data (dec_take)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = (size_ok && cmd_ok) ? ST_SEND : ST_DONE;
                end
            end
            ST_SEND: begin
                if (tx_ready && cur_last) state_d = ST_WAIT_RSP;
            end
            ST_WAIT_RSP: begin
                if (rsp_valid) state_d = dec_take ? ST_TAKE_DATA : ST_DONE;
            end
            ST_TAKE_DATA: begin
                if (rx_valid && (rem_q == RLEN_W'(1))) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign load    = (state_q == ST_IDLE) && req_valid;
    assign advance = (state_q == ST_SEND) && tx_ready;
    assign fwd     = (state_q == ST_TAKE_DATA) && rx_valid && (taken_q < size_q);

    // request and reply bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q    <= '0;
            is_read_q <= 1'b0;
            code_q    <= CPL_OK;
            reply_q   <= '0;
            count_q   <= '0;
            rem_q     <= '0;
            taken_q   <= '0;
        end else begin
            if (load) begin
                size_q    <= req_size;
                is_read_q <= is_read;
                reply_q   <= '0;
                count_q   <= '0;
                if (!size_ok)     code_q <= CPL_TOO_BIG;
                else if (!cmd_ok) code_q <= CPL_BAD_CMD;
                else              code_q <= CPL_OK;
            end
            if ((state_q == ST_WAIT_RSP) && rsp_valid) begin
                code_q  <= dec_code;
                reply_q <= dec_nib;
                count_q <= dec_keep;
                rem_q   <= rsp_len;
                taken_q <= '0;
            end
            if ((state_q == ST_TAKE_DATA) && rx_valid) begin
                rem_q <= rem_q - RLEN_W'(1);
                if (fwd) taken_q <= taken_q + SIZE_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        tx_valid   = 1'b0;
        tx_byte    = '0;
        tx_last    = 1'b0;
        rsp_ready  = 1'b0;
        rx_ready   = 1'b0;
        rd_valid   = 1'b0;
        rd_byte    = '0;
        done_valid = 1'b0;
        done_code  = '0;
        done_reply = '0;
        done_count = '0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_SEND: begin
                tx_valid = 1'b1;
                tx_byte  = cur_byte;
                tx_last  = cur_last;
            end
            ST_WAIT_RSP: rsp_ready = 1'b1;
            ST_TAKE_DATA: begin
                rx_ready = 1'b1;
                rd_valid = fwd;
                rd_byte  = fwd ? rx_byte : 8'h00;
            end
            ST_DONE: begin
                done_valid = 1'b1;
                done_code  = code_q;
                done_reply = reply_q;
                done_count = count_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/aux_req_fmt_chk.sv
module aux_req_fmt_chk #(
    parameter int MAX_PAYLOAD = 16,
    parameter int SIZE_W      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [3:0]        req_cmd,
    input logic [SIZE_W-1:0] req_size,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_byte,
    input logic              tx_last,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              rd_valid,
    input logic              done_valid,
    input logic [2:0]        done_code,
    input logic [3:0]        done_reply,
    input logic [SIZE_W-1:0] done_count
);

    logic [3:0] base_cmd;
    logic       legal_cmd;
    assign base_cmd  = req_cmd & 4'hB;
    assign legal_cmd = (base_cmd == 4'h0) || (base_cmd == 4'h1) ||
                       (base_cmd == 4'h8) || (base_cmd == 4'h9);

    AST_OVERSIZE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_size > SIZE_W'(MAX_PAYLOAD)))
        |=> (done_valid && (done_code == 3'd4) && !tx_valid)); // R1

    AST_BAD_CMD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_size <= SIZE_W'(MAX_PAYLOAD)) && !legal_cmd)
        |=> (done_valid && (done_code == 3'd5) && !tx_valid)); // R2

    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_last))); // R10

    AST_BUSY_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !req_ready); // R10

    AST_FAILURE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && (done_code >= 3'd1) && (done_code <= 3'd3))
        |-> ((done_reply == 4'd0) && (done_count == '0))); // R8

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && (done_code == 3'd0)) |-> (done_count <= SIZE_W'(MAX_PAYLOAD))); // R9

    AST_FWD_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rx_valid && rx_ready)); // R9

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready)); // R11

endmodule

bind aux_req_fmt aux_req_fmt_chk #(
    .MAX_PAYLOAD (MAX_PAYLOAD),
    .SIZE_W      (SIZE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_cmd    (req_cmd),
    .req_size   (req_size),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_byte    (tx_byte),
    .tx_last    (tx_last),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rd_valid   (rd_valid),
    .done_valid (done_valid),
    .done_code  (done_code),
    .done_reply (done_reply),
    .done_count (done_count)
);

// File: tb/aux_req_fmt_test.sv
`timescale 1ns/1ps
module aux_req_fmt_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [3:0]   req_cmd = '0;
    logic [15:0]  req_addr = '0;
    logic [4:0]   req_size = '0;
    logic [127:0] req_payload = '0;
    logic         tx_valid;
    logic         tx_ready = 1'b0;
    logic [7:0]   tx_byte;
    logic         tx_last;
    logic         rsp_valid = 1'b0;
    logic         rsp_ready;
    logic [7:0]   rsp_status = '0;
    logic [7:0]   rsp_reply = '0;
    logic [7:0]   rsp_len = '0;
    logic         rx_valid = 1'b0;
    logic         rx_ready;
    logic [7:0]   rx_byte = '0;
    logic         rd_valid;
    logic [7:0]   rd_byte;
    logic         done_valid;
    logic [2:0]   done_code;
    logic [3:0]   done_reply;
    logic [4:0]   done_count;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    aux_req_fmt uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_size(req_size), .req_payload(req_payload),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte), .tx_last(tx_last),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
        .rsp_reply(rsp_reply), .rsp_len(rsp_len),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte),
        .rd_valid(rd_valid), .rd_byte(rd_byte),
        .done_valid(done_valid), .done_code(done_code),
        .done_reply(done_reply), .done_count(done_count)
    );

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_one(input logic [3:0] cmd, input logic [15:0] addr, input int size,
                           input logic [7:0] st, input int rlen, input logic [7:0] rep);
        logic [7:0] exp_b [20];
        logic [3:0] base;
        bit   rd, cok, ok, brk;
        int   len, n, cyc, exp_code, exp_cnt, exp_rep;
        logic [3:0] hi;

        base = cmd & 4'hB;
        cok  = (base == 4'h0) || (base == 4'h1) || (base == 4'h8) || (base == 4'h9);
        rd   = base[0];

        chk(req_ready == 1'b1, "R10 ready when idle", int'(req_ready), 1);
        req_valid = 1'b1;
        req_cmd   = cmd;
        req_addr  = addr;
        req_size  = 5'(size);
        for (int k = 0; k < 16; k++) req_payload[k*8 +: 8] = 8'(addr[7:0] + 8'(k*7) + 8'd1);
        step();
        req_valid = 1'b0;

        if (size > 16 || !cok) begin
            exp_code = (size > 16) ? 4 : 5;
            chk(done_valid == 1'b1, (size > 16) ? "R1 refusal pulse" : "R2 refusal pulse",
                int'(done_valid), 1);
            chk(int'(done_code) == exp_code, (size > 16) ? "R1 refusal code" : "R2 refusal code",
                int'(done_code), exp_code);
            chk(tx_valid == 1'b0, (size > 16) ? "R1 no bytes" : "R2 no bytes", int'(tx_valid), 0);
            step();
            chk(done_valid == 1'b0 && req_ready == 1'b1, "R11 pulse ends",
                int'(done_valid), 0);
            return;
        end

        if (size == 0)  hi = 4'd3;
        else if (rd)    hi = 4'd4;
        else            hi = 4'((4 + size) % 16);
        exp_b[0] = addr[7:0];
        exp_b[1] = addr[15:8];
        exp_b[2] = {cmd, 4'h0};
        exp_b[3] = {hi, (size == 0) ? 4'd0 : 4'(size - 1)};
        for (int k = 0; k < 16; k++) exp_b[4+k] = 8'(addr[7:0] + 8'(k*7) + 8'd1);
        len = rd ? 4 : 4 + size;

        n = 0; cyc = 0; brk = 1'b0;
        while (n < len && !brk) begin
            if (!tx_valid) begin
                chk(1'b0, "R5 frame length short", n, len);
                brk = 1'b1;
            end else begin
                if (n < 3)
                    chk(tx_byte == exp_b[n], "R3 header byte", int'(tx_byte), int'(exp_b[n]));
                else if (n == 3) begin
                    chk(tx_byte[3:0] == exp_b[3][3:0], "R4 size nibble",
                        int'(tx_byte[3:0]), int'(exp_b[3][3:0]));
                    chk(tx_byte[7:4] == hi,
                        (size == 0) ? "R6 bare length nibble" : (rd ? "R7 read length nibble"
                                                                    : "R5 write length nibble"),
                        int'(tx_byte[7:4]), int'(hi));
                end else
                    chk(tx_byte == exp_b[n], "R5 payload byte", int'(tx_byte), int'(exp_b[n]));
                chk(tx_last == (n == len - 1), "R10 last flag", int'(tx_last), int'(n == len - 1));
                if (n == 0) chk(req_ready == 1'b0, "R10 busy while sending", int'(req_ready), 0);
                tx_ready = ((cyc % 3) != 2);
                step();
                if (tx_ready) n++;
                tx_ready = 1'b0;
                cyc++;
            end
        end

        chk(tx_valid == 1'b0, (size == 0) ? "R6 frame ends" : (rd ? "R7 frame ends" : "R5 frame ends"),
            int'(tx_valid), 0);
        chk(rsp_ready == 1'b1, "R8 waiting for reply", int'(rsp_ready), 1);
        rsp_valid  = 1'b1;
        rsp_status = st;
        rsp_reply  = rep;
        rsp_len    = 8'(rlen);
        step();
        rsp_valid = 1'b0;

        ok = !(st == 8'd1 || st == 8'd2 || st == 8'd3);
        if (ok && rd && rlen > 0) begin
            for (int i = 0; i < rlen; i++) begin
                rx_valid = 1'b1;
                rx_byte  = 8'(8'hA0 + i);
                #1;
                chk(rd_valid == (i < size), "R9 forward gating", int'(rd_valid), int'(i < size));
                if (i < size) chk(rd_byte == rx_byte, "R9 forward value", int'(rd_byte), int'(rx_byte));
                step();
            end
            rx_valid = 1'b0;
        end

        exp_code = ok ? 0 : int'(st);
        exp_rep  = ok ? int'(rep[7:4]) : 0;
        if (!ok)      exp_cnt = 0;
        else if (!rd) exp_cnt = size;
        else          exp_cnt = (rlen < size) ? rlen : size;
        chk(done_valid == 1'b1, "R11 completion pulse", int'(done_valid), 1);
        chk(int'(done_code) == exp_code, ok ? "R9 success code" : "R8 failure code",
            int'(done_code), exp_code);
        chk(int'(done_reply) == exp_rep, ok ? "R9 reply nibble" : "R8 reply cleared",
            int'(done_reply), exp_rep);
        chk(int'(done_count) == exp_cnt, ok ? "R9 byte count" : "R8 count cleared",
            int'(done_count), exp_cnt);
        step();
        chk(done_valid == 1'b0 && req_ready == 1'b1, "R11 ready after pulse", int'(req_ready), 1);
    endtask

    initial begin
        logic [7:0] stat_tab [5];
        stat_tab[0] = 8'd0; stat_tab[1] = 8'd1; stat_tab[2] = 8'd2;
        stat_tab[3] = 8'd3; stat_tab[4] = 8'd7;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R11 reset ready", int'(req_ready), 1);
        chk(tx_valid == 1'b0 && done_valid == 1'b0 && rsp_ready == 1'b0, "R11 reset outputs",
            int'(tx_valid), 0);
        rst_n = 1'b1;
        step();
        for (int c = 0; c < 16; c++) begin
            for (int s = 0; s < 18; s++) begin
                run_one(4'(c), {4'(c), 4'(s), 8'(c*29 + s*11)}, s,
                        stat_tab[(c + s) % 5], (s*5 + c) % 20, {4'(c ^ 5), 4'hC});
            end
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule